// File: doc/BRIEF.md
# Monochrome Row-Buffer Display Timing Generator

This block drives a one-bit-per-pixel monochrome display. The frame is held in a dual-ported row store in which every word is one complete display row. A host writes rows through one port, one row per write, and can do so at any time. The display side runs a horizontal and a vertical counter that produce the sync pulses. In the blanking gap that comes before each visible line, the display side reads that line's row word through the other port into a parallel shift register. It then shifts the pixels out serially, one per pixel clock, during the active part of the line.

At the default settings the image is 720 pixels by 350 lines. A line lasts 882 pixel clocks, which is about 18.4 kHz at a pixel clock near 16.26 MHz. A frame is 370 lines long, about 50 Hz. Every porch and sync width is a parameter, and the intensity output is a build-time constant. The horizontal blanking gap must be at least three clocks long so that the row can be fetched and loaded.

Top module: `mono_raster`

## Requirements
- R1: Whenever rst_n is sampled low, the next clock edge sets hsync to 0, vsync_n to 1 and video to 0, and places both counters at the first line of vertical blanking. After release, the first vsync_n low is seen on the (1 + V_FP·H_TOTAL)-th rising edge.
- R2: A line is H_TOTAL = PIX_W+H_FP+H_SYNC+H_BP clocks long. hsync is active high for H_SYNC clocks and starts at pixel position PIX_W+H_FP of the line.
- R3: A frame is V_TOTAL = V_ACTIVE+V_FP+V_SYNC+V_BP lines long. vsync_n is active low for V_SYNC whole lines and starts at line V_ACTIVE+V_FP.
- R4: At pixel position c of visible line v, video equals bit c of row word v. Bit 0 is the leftmost pixel and is shown first.
- R5: Outside the active region (pixel position at or above PIX_W, or line at or above V_ACTIVE), video is 0 whatever the row contents are.
- R6: A host write of wr_data to row wr_row (taken on a clock with wr_en high) is shown the next time that row is displayed, provided the write comes before that row's fetch. The fetch happens at pixel position PIX_W of the line above.
- R7: A write that lands after a row has been fetched does not change the line being shown from that fetch. The line shows the whole old word, with no mix of old and new, and the new word appears from the next frame on.
- R8: The intensity output always equals the INTENSITY parameter (1 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host row write strobe |
| wr_row | input | RW = clog2(V_ACTIVE) | Row index of the host write |
| wr_data | input | PIX_W | Row word to store, bit 0 = leftmost pixel |
| hsync | output | 1 | Horizontal sync, active high |
| vsync_n | output | 1 | Vertical sync, active low |
| video | output | 1 | Serial pixel output |
| intensity | output | 1 | Constant intensity level |

## Verification
The pixel path is driven with rows that each catch a different fault. A full row of ones shows any blanking leak. A single bit at the far left or far right catches a reversed shift direction and a lost end pixel. Irregular mixed words catch a swapped or stale row address. Writes are placed at chosen points of the raster: before a row's fetch, on the row currently on screen, and just after the next row's fetch. Together these show when the fetch happens and that a line never tears. Sync placement and the line and frame periods are measured by counting edges, and they are measured again after a reset in mid-frame.

// File: rtl/mono_raster_pkg.sv
// Package: shared types for the monochrome raster generator.
// Assumes: callers pass non-negative positions and span widths.
package mono_raster_pkg;

    // Part of a line (or of a frame) that a counter position falls into
    typedef enum logic [1:0] {
        SPAN_ACTIVE,
        SPAN_FRONT,
        SPAN_SYNC,
        SPAN_BACK
    } span_t;

    // Maps a counter position onto its span, given the span widths
    function automatic span_t span_of(input int pos, input int act,
                                      input int front, input int sync_w);
        if (pos < act)                       return SPAN_ACTIVE;
        else if (pos < act + front)          return SPAN_FRONT;
        else if (pos < act + front + sync_w) return SPAN_SYNC;
        else                                 return SPAN_BACK;
    endfunction

endpackage

// File: rtl/mono_raster_timing.sv
// Module: raster counters, sync decode and row-fetch scheduling.
// What it does: counts pixel and line positions, decodes the active region
// and the raw sync levels, and requests the next line's row at the first
// blanking clock of each line. load follows the request by one clock, which
// matches the row store's one-clock read latency.
// Assumes: H_FP+H_SYNC+H_BP >= 3, and reset starts at the first vblank line.
module mono_raster_timing
    import mono_raster_pkg::*;
#(
    parameter int H_ACTIVE = 720,
    parameter int H_FP     = 10,
    parameter int H_SYNC   = 135,
    parameter int H_BP     = 17,
    parameter int V_ACTIVE = 350,
    parameter int V_FP     = 4,
    parameter int V_SYNC   = 14,
    parameter int V_BP     = 2,
    parameter int RW       = (V_ACTIVE > 1) ? $clog2(V_ACTIVE) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          active,
    output logic          hsync_raw,
    output logic          vsync_n_raw,
    output logic          fetch_en,
    output logic [RW-1:0] fetch_row,
    output logic          load
);
    localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
    localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
    localparam int HW      = $clog2(H_TOTAL);
    localparam int VW      = $clog2(V_TOTAL);
    localparam logic [HW-1:0] H_LAST  = HW'(H_TOTAL - 1);
    localparam logic [HW-1:0] H_FETCH = HW'(H_ACTIVE);
    localparam logic [VW-1:0] V_LAST  = VW'(V_TOTAL - 1);
    localparam logic [VW-1:0] V_START = VW'(V_ACTIVE);

    logic [HW-1:0] h_cnt;
    logic [VW-1:0] v_cnt;
    logic [VW-1:0] v_next;
    span_t         h_span;
    span_t         v_span;

    // Pixel and line counters; reset lands on the first vblank line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_cnt <= '0;
            v_cnt <= V_START;
        end else if (h_cnt == H_LAST) begin
            h_cnt <= '0;
            v_cnt <= v_next;
        end else begin
            h_cnt <= h_cnt + 1'b1;
        end
    end

    // Line index that follows the current one, wrapping at frame end
    always_comb begin
        v_next = (v_cnt == V_LAST) ? '0 : v_cnt + 1'b1;
    end

    // Span decode and raw sync levels
    always_comb begin
        h_span      = span_of(int'(h_cnt), H_ACTIVE, H_FP, H_SYNC);
        v_span      = span_of(int'(v_cnt), V_ACTIVE, V_FP, V_SYNC);
        active      = (h_span == SPAN_ACTIVE) && (v_span == SPAN_ACTIVE);
        hsync_raw   = (h_span == SPAN_SYNC);
        vsync_n_raw = (v_span != SPAN_SYNC);
    end

    // Row read request at the first blanking clock, only for visible rows
    always_comb begin
        fetch_en  = (h_cnt == H_FETCH) && (int'(v_next) < V_ACTIVE);
        fetch_row = RW'(v_next);
    end

    // Shift-register load strobe, one clock after the read request
    always_ff @(posedge clk) begin
        if (!rst_n) load <= 1'b0;
        else        load <= fetch_en;
    end

endmodule

// File: rtl/mono_raster_rowstore.sv
// Module: dual-ported row store, one display row per word.
// What it does: the host writes whole rows through port A; the display reads
// a row through port B with a one-clock registered output. If both ports hit
// the same row on the same clock, the read returns the old word.
// Assumes: writes to row indexes at or above DEPTH are dropped.
module mono_raster_rowstore #(
    parameter int WIDTH = 720,
    parameter int DEPTH = 350,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);
    localparam logic [AW:0] DEPTH_W = (AW+1)'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];

    // Host write port, bounded to the visible rows
    always_ff @(posedge clk) begin
        if (wr_en && ({1'b0, wr_addr} < DEPTH_W)) mem[wr_addr] <= wr_data;
    end

    // Display read port with a registered output
    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/mono_raster_shifter.sv
// Module: parallel-load, serial-out pixel register.
// What it does: takes a whole row word on load and moves it one place toward
// bit 0 on each shift clock; pix is always bit 0 (the leftmost pixel).
// Assumes: load and shift never fall on the same clock (load wins if they do).
module mono_raster_shifter #(
    parameter int WIDTH = 720
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic [WIDTH-1:0] din,
    output logic             pix
);
    logic [WIDTH-1:0] sr;

    // Row register: cleared on reset, loaded per line, shifted per pixel
    always_ff @(posedge clk) begin
        if (!rst_n)     sr <= '0;
        else if (load)  sr <= din;
        else if (shift) sr <= {1'b0, sr[WIDTH-1:1]};
    end

    assign pix = sr[0];

endmodule

// File: rtl/mono_raster.sv
// Module: top of the monochrome row-buffer raster generator.
// What it does: ties the counters, row store and pixel shifter together and
// registers hsync, vsync_n and video so that all three leave the block in
// step, one clock after the counter position they describe.
// Assumes: synchronous active-low reset; the host may write at any time.
module mono_raster #(
    parameter int PIX_W     = 720,
    parameter int H_FP      = 10,
    parameter int H_SYNC    = 135,
    parameter int H_BP      = 17,
    parameter int V_ACTIVE  = 350,
    parameter int V_FP      = 4,
    parameter int V_SYNC    = 14,
    parameter int V_BP      = 2,
    parameter bit INTENSITY = 1'b1,
    parameter int RW        = (V_ACTIVE > 1) ? $clog2(V_ACTIVE) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [RW-1:0]    wr_row,
    input  logic [PIX_W-1:0] wr_data,
    output logic             hsync,
    output logic             vsync_n,
    output logic             video,
    output logic             intensity
);
    localparam int H_TOTAL = PIX_W + H_FP + H_SYNC + H_BP;
    localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;

    logic             t_active;
    logic             t_hsync;
    logic             t_vsync_n;
    logic             fetch_en;
    logic [RW-1:0]    fetch_row;
    logic             load;
    logic [PIX_W-1:0] row_word;
    logic             pix;

    mono_raster_timing #(
        .H_ACTIVE (PIX_W),
        .H_FP     (H_FP),
        .H_SYNC   (H_SYNC),
        .H_BP     (H_BP),
        .V_ACTIVE (V_ACTIVE),
        .V_FP     (V_FP),
        .V_SYNC   (V_SYNC),
        .V_BP     (V_BP),
        .RW       (RW)
    ) u_timing (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (t_active),
        .hsync_raw   (t_hsync),
        .vsync_n_raw (t_vsync_n),
        .fetch_en    (fetch_en),
        .fetch_row   (fetch_row),
        .load        (load)
    );

    mono_raster_rowstore #(
        .WIDTH (PIX_W),
        .DEPTH (V_ACTIVE),
        .AW    (RW)
    ) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_row),
        .wr_data (wr_data),
        .rd_en   (fetch_en),
        .rd_addr (fetch_row),
        .rd_data (row_word)
    );

    mono_raster_shifter #(
        .WIDTH (PIX_W)
    ) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .shift (t_active),
        .din   (row_word),
        .pix   (pix)
    );

    // Output stage: sync levels and gated pixel, idle values in reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsync   <= 1'b0;
            vsync_n <= 1'b1;
            video   <= 1'b0;
        end else begin
            hsync   <= t_hsync;
            vsync_n <= t_vsync_n;
            video   <= t_active & pix;
        end
    end

    assign intensity = INTENSITY;

endmodule

// File: rtl/mono_raster_chk.sv
// Module: assertion checker bound to mono_raster.
// What it does: watches the output pins for sync width, line and frame
// period, blanking and reset values. The periods are checked with counters,
// not deep $past windows.
// Assumes: the same synchronous active-low reset as the design.
module mono_raster_chk #(
    parameter int H_TOTAL = 882,
    parameter int V_TOTAL = 370,
    parameter int H_SYNC  = 135
) (
    input logic clk,
    input logic rst_n,
    input logic hsync,
    input logic vsync_n,
    input logic video
);
    int   hs_run;
    int   h_gap;
    int   f_gap;
    logic hs_q;
    logic vs_q;
    logic h_seen;
    logic f_seen;

    // Tracks the sync run length and the gaps between sync edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_run <= 0;
            h_gap  <= 0;
            f_gap  <= 0;
            hs_q   <= 1'b0;
            vs_q   <= 1'b1;
            h_seen <= 1'b0;
            f_seen <= 1'b0;
        end else begin
            hs_q   <= hsync;
            vs_q   <= vsync_n;
            hs_run <= hsync ? hs_run + 1 : 0;
            if (hsync && !hs_q) begin
                h_gap  <= 0;
                h_seen <= 1'b1;
            end else begin
                h_gap <= h_gap + 1;
            end
            if (!vsync_n && vs_q) begin
                f_gap  <= 0;
                f_seen <= 1'b1;
            end else begin
                f_gap <= f_gap + 1;
            end
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!hsync && vsync_n && !video));

    // R2
    hsync_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hsync) |-> (hs_run == H_SYNC));

    // R2
    line_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hsync) && h_seen) |-> (h_gap == H_TOTAL - 1));

    // R3
    frame_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(vsync_n) && f_seen) |-> (f_gap == H_TOTAL * V_TOTAL - 1));

    // R5
    blank_video_chk: assert property (@(posedge clk) disable iff (!rst_n)
        video |-> (!hsync && vsync_n));

endmodule

bind mono_raster mono_raster_chk #(
    .H_TOTAL (H_TOTAL),
    .V_TOTAL (V_TOTAL),
    .H_SYNC  (H_SYNC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hsync   (hsync),
    .vsync_n (vsync_n),
    .video   (video)
);

// File: tb/mono_raster_bench.sv
// Directed bench for mono_raster at a reduced raster (16x4 visible).
module mono_raster_bench;
    localparam int PW  = 16;
    localparam int HFP = 2;
    localparam int HSY = 3;
    localparam int HBP = 3;
    localparam int VA  = 4;
    localparam int VFP = 1;
    localparam int VSY = 2;
    localparam int VBP = 1;
    localparam int HT  = PW + HFP + HSY + HBP;
    localparam int VT  = VA + VFP + VSY + VBP;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_row = '0;
    logic [PW-1:0] wr_data = '0;
    logic          hsync;
    logic          vsync_n;
    logic          video;
    logic          intensity;

    int total = 0;
    int bad = 0;
    int ph = 0;
    int pv = 0;
    bit started = 1'b0;

    always #2 clk = ~clk;

    mono_raster #(
        .PIX_W (PW), .H_FP (HFP), .H_SYNC (HSY), .H_BP (HBP),
        .V_ACTIVE (VA), .V_FP (VFP), .V_SYNC (VSY), .V_BP (VBP),
        .INTENSITY (1'b1)
    ) u_mono_raster (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_row (wr_row),
        .wr_data (wr_data), .hsync (hsync), .vsync_n (vsync_n),
        .video (video), .intensity (intensity)
    );

    // Position that the registered outputs describe, rebuilt from the requirements
    always @(posedge clk) begin
        if (!rst_n) started <= 1'b0;
        else if (!started) begin
            started <= 1'b1; ph <= 0; pv <= VA;
        end else if (ph == HT - 1) begin
            ph <= 0; pv <= (pv == VT - 1) ? 0 : pv + 1;
        end else ph <= ph + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic wait_pos(input int h, input int v);
        do @(negedge clk); while (!(started && ph == h && pv == v));
    endtask

    task automatic put_row(input int r, input logic [PW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_row = 2'(r); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Captures one visible line; optionally issues a write at column wcol
    task automatic grab_line(input int v, input bit do_wr, input int wcol,
                             input int wr, input logic [PW-1:0] wd,
                             output logic [PW-1:0] got);
        for (int c = 0; c < PW; c++) begin
            wait_pos(c, v);
            wr_en = 1'b0;
            got[c] = video;
            if (do_wr && c == wcol) begin
                wr_en = 1'b1; wr_row = 2'(wr); wr_data = wd;
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic count_to_vsync(output int n);
        n = 0;
        do begin
            @(posedge clk); n++; @(negedge clk);
        end while (vsync_n !== 1'b0 && n < 1000);
    endtask

    logic [PW-1:0] img [VA];

    task automatic t_reset_and_load();
        int n;
        rst_n = 1'b0;
        img[0] = 16'hFFFF; img[1] = 16'h0001; img[2] = 16'h8000; img[3] = 16'hA5C3;
        for (int r = 0; r < VA; r++) put_row(r, img[r]);
        @(negedge clk);
        // R1: idle levels in reset; R8 intensity constant
        check(hsync === 1'b0 && vsync_n === 1'b1 && video === 1'b0, "R1 reset idle",
              {hsync, vsync_n, video}, 3'b010);
        check(intensity === 1'b1, "R8 intensity", intensity, 1);
        rst_n = 1'b1;
        count_to_vsync(n);
        // R1: counters start at the first vblank line
        check(n == 1 + VFP * HT, "R1 start in vblank", n, 1 + VFP * HT);
    endtask

    task automatic t_sync();
        int n;
        wait_pos(HFP + PW - 1, 0); check(hsync === 1'b0, "R2 hsync before", hsync, 0);
        wait_pos(PW + HFP, 0);     check(hsync === 1'b1, "R2 hsync start", hsync, 1);
        n = 0;
        do begin @(negedge clk); n++; end while (hsync === 1'b1 && n < 100);
        check(n == HSY, "R2 hsync width", n, HSY);
        n = 0;
        do begin @(negedge clk); n++; end while (hsync !== 1'b1 && n < 100);
        check(n == HT - HSY, "R2 line period", n + HSY, HT);
        wait_pos(HT - 1, VA);      check(vsync_n === 1'b1, "R3 vsync before", vsync_n, 1);
        wait_pos(0, VA + VFP);     check(vsync_n === 1'b0, "R3 vsync start", vsync_n, 0);
        wait_pos(HT - 1, VA + VFP + VSY - 1);
        check(vsync_n === 1'b0, "R3 vsync last", vsync_n, 0);
        wait_pos(0, VA + VFP + VSY); check(vsync_n === 1'b1, "R3 vsync end", vsync_n, 1);
        n = 0;
        do begin @(negedge clk); n++; end while (vsync_n !== 1'b0 && n < 1000);
        check(n == HT * VT - HT * VSY, "R3 frame period", n + HT * VSY, HT * VT);
    endtask

    task automatic t_pixels();
        logic [PW-1:0] got;
        for (int v = 0; v < VA; v++) begin
            grab_line(v, 1'b0, 0, 0, '0, got);
            check(got === img[v], "R4 row pixels", got, img[v]);
        end
    endtask

    task automatic t_blank();
        bit leak;
        leak = 1'b0;
        for (int h = PW; h < HT; h++) begin wait_pos(h, 0); leak |= (video !== 1'b0); end
        check(!leak, "R5 hblank video", leak, 0);
        leak = 1'b0;
        for (int v = VA; v < VT; v++)
            for (int h = 0; h < HT; h++) begin wait_pos(h, v); leak |= (video !== 1'b0); end
        check(!leak, "R5 vblank video", leak, 0);
    endtask

    task automatic t_write_timing();
        logic [PW-1:0] got;
        // R6: write row 3 while line 2 is shown, before row 3 is fetched
        grab_line(2, 1'b1, 5, 3, 16'h1234, got);
        check(got === img[2], "R6 line2 unaffected", got, img[2]);
        img[3] = 16'h1234;
        grab_line(3, 1'b0, 0, 0, '0, got);
        check(got === 16'h1234, "R6 new row shown", got, 16'h1234);
        // R7: write row 1 while line 1 is shown; line keeps old word
        grab_line(1, 1'b1, 6, 1, 16'h7E00, got);
        check(got === img[1], "R7 no tearing", got, img[1]);
        grab_line(1, 1'b0, 0, 0, '0, got);
        check(got === 16'h7E00, "R7 next frame new", got, 16'h7E00);
        img[1] = 16'h7E00;
        // R7: write row 3 just after its fetch; line 3 keeps the fetched word
        wait_pos(PW + 3, 2);
        wr_en = 1'b1; wr_row = 2'd3; wr_data = 16'h00F1;
        @(negedge clk); wr_en = 1'b0;
        grab_line(3, 1'b0, 0, 0, '0, got);
        check(got === 16'h1234, "R7 write after fetch", got, 16'h1234);
        grab_line(3, 1'b0, 0, 0, '0, got);
        check(got === 16'h00F1, "R7 after-fetch next frame", got, 16'h00F1);
        img[3] = 16'h00F1;
    endtask

    task automatic t_mid_reset();
        int n;
        logic [PW-1:0] got;
        wait_pos(7, 1);
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        check(hsync === 1'b0 && vsync_n === 1'b1 && video === 1'b0, "R1 mid reset idle",
              {hsync, vsync_n, video}, 3'b010);
        rst_n = 1'b1;
        count_to_vsync(n);
        check(n == 1 + VFP * HT, "R1 mid reset vblank", n, 1 + VFP * HT);
        grab_line(0, 1'b0, 0, 0, '0, got);
        check(got === img[0], "R4 after reset row0", got, img[0]);
        check(intensity === 1'b1, "R8 intensity late", intensity, 1);
    endtask

    // Watchdog: a hung run counts as one failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        t_reset_and_load();
        t_sync();
        t_pixels();
        t_blank();
        t_write_timing();
        t_mid_reset();
        summary();
    end

endmodule